// File: doc/BRIEF.md
# Per-CPU Interrupt Priority Arbiter

This block chooses, for every CPU, the most urgent interrupt that is both enabled and pending for that CPU. It then decides whether that choice is visible to the CPU and whether it may interrupt the work the CPU is doing now. Enable bits are global, one per interrupt. Pending bits are kept per CPU. Priorities come in as two arrays: one banked copy per CPU for the low IDs (below `BANKED`), and one shared value for each higher ID. For each CPU the block returns a highest-pending ID and one request line.

The winner is found by a balanced comparison tree. A numerically smaller priority wins. On equal priority the smaller ID wins, because the left branch is kept on a tie. Each CPU then has a small state register whose state says where the winner stopped:
- **OFF**: the distributor or the CPU interface is disabled.
- **EMPTY**: there is no candidate.
- **MASKED**: the winner's priority is above the CPU's mask.
- **HELD**: the winner passes the mask but is not more urgent than the running priority.
- **REQ**: the request line is raised.

Every clock, the next state is taken from the first of these conditions that holds, checked in the order OFF, EMPTY, MASKED, HELD, REQ. Any state can move to any other state in one clock. The per-CPU priority mask is held inside the block, resets to 0xF0, and is loaded by a per-CPU write strobe.

Top module: `prio_arbiter`

## Requirements
- R1: Among candidates of one CPU, the one with the numerically smaller 8-bit priority is reported as that CPU's highest-pending ID.
- R2: When candidates have equal priority, the smaller interrupt ID is reported.
- R3: An interrupt is a candidate for CPU c only when `irq_en[k]` and `irq_pend[c*NUM_IRQ+k]` are both 1. With no candidate, the ID is 1023 and the request is low.
- R4: When `dist_en` is 0, or `cpu_en[c]` is 0, CPU c has request 0 and ID 1023.
- R5: The winner's ID is reported only when its priority is less than or equal to the CPU's mask. Otherwise the ID reads 1023 and the request is low.
- R6: The request for CPU c is 1 only when the winner passes the mask and its priority is strictly less than the 9-bit running priority `run_prio[c*9+:9]`. An equal value gives ID reported with request 0.
- R7: A running priority of 0x100 (idle) ranks below every 8-bit priority, so a winner with priority 0xFF that passes the mask raises the request.
- R8: For IDs below 32, the priority of ID k for CPU c is `prio_bank[(c*32+k)*8+:8]`. For IDs of 32 and above, it is the shared value `prio_shared[(k-32)*8+:8]`.
- R9: After reset every ID output is 1023, every request is low, and every mask is 0xF0.
- R10: Outputs reflect a change on the state inputs after exactly one rising clock edge.
- R11: The mask of CPU c takes `mask_wdata` at an edge where `mask_wr[c]` is 1, and holds otherwise. Mask changes affect outputs one edge after they load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dist_en | input | 1 | Global distributor enable |
| cpu_en | input | NUM_CPU | Per-CPU interface enable |
| irq_en | input | NUM_IRQ | Per-interrupt enable |
| irq_pend | input | NUM_CPU*NUM_IRQ | Pending bits, CPU c interrupt k at c*NUM_IRQ+k |
| prio_bank | input | NUM_CPU*BANKED*8 | Banked priorities for low IDs |
| prio_shared | input | (NUM_IRQ-BANKED)*8 | Shared priorities for high IDs |
| mask_wr | input | NUM_CPU | Per-CPU mask load strobe |
| mask_wdata | input | 8 | Mask value to load |
| run_prio | input | NUM_CPU*9 | Per-CPU running priority, 0x100 = idle |
| hp_id | output | NUM_CPU*10 | Highest-pending ID per CPU, 1023 = none |
| irq_req | output | NUM_CPU | Interrupt request per CPU |

## Verification
The hardest situation to reach is the split between the HELD and REQ states. In HELD, the ID is visible but the request is low. Getting there needs a winner that passes the mask while its priority equals the running priority exactly. The stimulus first loads a wider mask through the strobe. It then sets the running priority to the winner's value, and then one step above it, so that both sides of the strict comparison are seen. Banked-versus-shared routing is reached by giving one low ID different banked values on the two CPUs, so that each CPU chooses a different winner.

// File: rtl/prio_arb_pkg.sv
package prio_arb_pkg;

    localparam int PRIO_W = 8;
    localparam int ID_W   = 10;
    localparam int RUN_W  = PRIO_W + 1;

    localparam logic [ID_W-1:0]   NONE_ID  = '1;
    localparam logic [PRIO_W-1:0] MASK_RST = 8'hF0;

    typedef struct packed {
        logic              valid;
        logic [PRIO_W-1:0] prio;
        logic [ID_W-1:0]   id;
    } cand_t;

    typedef enum logic [2:0] {
        CS_OFF,
        CS_EMPTY,
        CS_MASKED,
        CS_HELD,
        CS_REQ
    } cpu_state_e;

    // Left operand carries the lower IDs; it is kept on a tie.
    function automatic cand_t cand_pick(input cand_t lo, input cand_t hi);
        cand_t r;
        if (!lo.valid)
            r = hi;
        else if (!hi.valid)
            r = lo;
        else if (hi.prio < lo.prio)
            r = hi;
        else
            r = lo;
        return r;
    endfunction

endpackage

// File: rtl/prio_route.sv
module prio_route
    import prio_arb_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int BANKED  = 32
) (
    input  logic [BANKED*PRIO_W-1:0]           bank_prio,
    input  logic [(NUM_IRQ-BANKED)*PRIO_W-1:0] shared_prio,
    output logic [NUM_IRQ*PRIO_W-1:0]          prio_vec
);

    for (genvar k = 0; k < NUM_IRQ; k++) begin : g_src
        if (k < BANKED) begin : g_bank
            assign prio_vec[k*PRIO_W +: PRIO_W] = bank_prio[k*PRIO_W +: PRIO_W];
        end else begin : g_share
            assign prio_vec[k*PRIO_W +: PRIO_W] = shared_prio[(k-BANKED)*PRIO_W +: PRIO_W];
        end
    end

endmodule

// File: rtl/irq_cand_tree.sv
module irq_cand_tree
    import prio_arb_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic [NUM_IRQ-1:0]        cand_ok,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_vec,
    output cand_t                     best
);

    localparam int DEPTH  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 0;
    localparam int LEAVES = 1 << DEPTH;

    for (genvar lvl = 0; lvl <= DEPTH; lvl++) begin : g_lvl
        cand_t node [LEAVES >> lvl];
        if (lvl == 0) begin : g_leaf
            for (genvar k = 0; k < LEAVES; k++) begin : g_k
                if (k < NUM_IRQ) begin : g_real
                    assign node[k].valid = cand_ok[k];
                    assign node[k].prio  = prio_vec[k*PRIO_W +: PRIO_W];
                    assign node[k].id    = ID_W'(k);
                end else begin : g_pad
                    assign node[k] = '0;
                end
            end
        end else begin : g_cmp
            for (genvar j = 0; j < (LEAVES >> lvl); j++) begin : g_j
                assign node[j] = cand_pick(g_lvl[lvl-1].node[2*j], g_lvl[lvl-1].node[2*j+1]);
            end
        end
    end

    assign best = g_lvl[DEPTH].node[0];

endmodule

// File: rtl/cpu_req_fsm.sv
module cpu_req_fsm
    import prio_arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gate_en,
    input  cand_t             win,
    input  logic              mask_wr,
    input  logic [PRIO_W-1:0] mask_wdata,
    input  logic [RUN_W-1:0]  run_prio,
    output logic [ID_W-1:0]   hp_id,
    output logic              irq_req,
    output logic [PRIO_W-1:0] mask_val
);

    cpu_state_e        state_q, state_d;
    logic [ID_W-1:0]   id_q, id_d;
    logic [PRIO_W-1:0] mask_q;

    always_comb begin
        if (!gate_en)
            state_d = CS_OFF;
        else if (!win.valid)
            state_d = CS_EMPTY;
        else if (win.prio > mask_q)
            state_d = CS_MASKED;
        else if ({1'b0, win.prio} >= run_prio)
            state_d = CS_HELD;
        else
            state_d = CS_REQ;
    end

    always_comb begin
        unique case (state_d)
            CS_HELD, CS_REQ: id_d = win.id;
            default:         id_d = NONE_ID;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CS_OFF;
            id_q    <= NONE_ID;
        end else begin
            state_q <= state_d;
            id_q    <= id_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= MASK_RST;
        else if (mask_wr)
            mask_q <= mask_wdata;
    end

    always_comb begin
        hp_id    = id_q;
        mask_val = mask_q;
        unique case (state_q)
            CS_REQ:  irq_req = 1'b1;
            default: irq_req = 1'b0;
        endcase
    end

endmodule

// File: rtl/prio_arbiter.sv
module prio_arbiter
    import prio_arb_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_CPU = 2,
    parameter int BANKED  = 32
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                dist_en,
    input  logic [NUM_CPU-1:0]                  cpu_en,
    input  logic [NUM_IRQ-1:0]                  irq_en,
    input  logic [NUM_CPU*NUM_IRQ-1:0]          irq_pend,
    input  logic [NUM_CPU*BANKED*PRIO_W-1:0]    prio_bank,
    input  logic [(NUM_IRQ-BANKED)*PRIO_W-1:0]  prio_shared,
    input  logic [NUM_CPU-1:0]                  mask_wr,
    input  logic [PRIO_W-1:0]                   mask_wdata,
    input  logic [NUM_CPU*RUN_W-1:0]            run_prio,
    output logic [NUM_CPU*ID_W-1:0]             hp_id,
    output logic [NUM_CPU-1:0]                  irq_req
);

    localparam int BANK_SLICE = BANKED * PRIO_W;

    logic [NUM_CPU*PRIO_W-1:0] mask_flat;

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        logic [NUM_IRQ*PRIO_W-1:0] prio_vec;
        logic [NUM_IRQ-1:0]        cand_ok;
        cand_t                     win;

        assign cand_ok = irq_en & irq_pend[c*NUM_IRQ +: NUM_IRQ];

        prio_route #(
            .NUM_IRQ (NUM_IRQ),
            .BANKED  (BANKED)
        ) u_route (
            .bank_prio   (prio_bank[c*BANK_SLICE +: BANK_SLICE]),
            .shared_prio (prio_shared),
            .prio_vec    (prio_vec)
        );

        irq_cand_tree #(
            .NUM_IRQ (NUM_IRQ)
        ) u_tree (
            .cand_ok  (cand_ok),
            .prio_vec (prio_vec),
            .best     (win)
        );

        cpu_req_fsm u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .gate_en    (dist_en & cpu_en[c]),
            .win        (win),
            .mask_wr    (mask_wr[c]),
            .mask_wdata (mask_wdata),
            .run_prio   (run_prio[c*RUN_W +: RUN_W]),
            .hp_id      (hp_id[c*ID_W +: ID_W]),
            .irq_req    (irq_req[c]),
            .mask_val   (mask_flat[c*PRIO_W +: PRIO_W])
        );
    end

endmodule

// File: rtl/prio_arbiter_chk.sv
module prio_arbiter_chk
    import prio_arb_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_CPU = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       dist_en,
    input logic [NUM_CPU-1:0]         cpu_en,
    input logic [NUM_IRQ-1:0]         irq_en,
    input logic [NUM_CPU*NUM_IRQ-1:0] irq_pend,
    input logic [NUM_CPU-1:0]         mask_wr,
    input logic [NUM_CPU*PRIO_W-1:0]  mask_flat,
    input logic [NUM_CPU*ID_W-1:0]    hp_id,
    input logic [NUM_CPU-1:0]         irq_req
);

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_c
        a_r4_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
            (!dist_en || !cpu_en[c]) |=> (!irq_req[c] && hp_id[c*ID_W +: ID_W] == NONE_ID));

        a_r3_no_cand: assert property (@(posedge clk) disable iff (!rst_n)
            ((irq_en & irq_pend[c*NUM_IRQ +: NUM_IRQ]) == '0)
                |=> (!irq_req[c] && hp_id[c*ID_W +: ID_W] == NONE_ID));

        a_r6_req_has_id: assert property (@(posedge clk) disable iff (!rst_n)
            irq_req[c] |-> hp_id[c*ID_W +: ID_W] != NONE_ID);

        a_r11_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !mask_wr[c] |=> $stable(mask_flat[c*PRIO_W +: PRIO_W]));

        a_r9_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(rst_n) |-> (!irq_req[c] && hp_id[c*ID_W +: ID_W] == NONE_ID
                               && mask_flat[c*PRIO_W +: PRIO_W] == MASK_RST));
    end

endmodule

bind prio_arbiter prio_arbiter_chk #(
    .NUM_IRQ (NUM_IRQ),
    .NUM_CPU (NUM_CPU)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dist_en   (dist_en),
    .cpu_en    (cpu_en),
    .irq_en    (irq_en),
    .irq_pend  (irq_pend),
    .mask_wr   (mask_wr),
    .mask_flat (mask_flat),
    .hp_id     (hp_id),
    .irq_req   (irq_req)
);

// File: tb/prio_arbiter_bench.sv
module prio_arbiter_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 64;
    localparam int NC = 2;
    localparam int NB = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              dist_en = 1'b0;
    logic [NC-1:0]     cpu_en = '0;
    logic [N-1:0]      irq_en = '0;
    logic [NC*N-1:0]   irq_pend = '0;
    logic [NC*NB*8-1:0] prio_bank = '1;
    logic [(N-NB)*8-1:0] prio_shared = '1;
    logic [NC-1:0]     mask_wr = '0;
    logic [7:0]        mask_wdata = '0;
    logic [NC*9-1:0]   run_prio = {NC{9'h100}};
    logic [NC*10-1:0]  hp_id;
    logic [NC-1:0]     irq_req;

    int total = 0;
    int bad = 0;
    int m_mask [NC];

    typedef struct {
        int    cpu;
        int    id;
        bit    req;
        string tag;
    } exp_t;
    exp_t sb_q [$];
    event chk_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_arbiter #(.NUM_IRQ(N), .NUM_CPU(NC), .BANKED(NB)) u_prio_arbiter (
        .clk(clk), .rst_n(rst_n), .dist_en(dist_en), .cpu_en(cpu_en),
        .irq_en(irq_en), .irq_pend(irq_pend), .prio_bank(prio_bank),
        .prio_shared(prio_shared), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
        .run_prio(run_prio), .hp_id(hp_id), .irq_req(irq_req)
    );

    function automatic int prio_of(int c, int k);
        if (k < NB) return int'(prio_bank[(c*NB+k)*8 +: 8]);
        return int'(prio_shared[(k-NB)*8 +: 8]);
    endfunction

    task automatic model(input int c, output int id, output bit req);
        int best = -1;
        int bp = 256;
        id = 1023;
        req = 1'b0;
        if (dist_en && cpu_en[c]) begin
            for (int k = 0; k < N; k++) begin
                if (irq_en[k] && irq_pend[c*N+k] && prio_of(c, k) < bp) begin
                    bp = prio_of(c, k);
                    best = k;
                end
            end
            if (best >= 0 && bp <= m_mask[c]) begin
                id = best;
                req = (bp < int'(run_prio[c*9 +: 9]));
            end
        end
    endtask

    // Driver side: push expected items, let the design advance, trigger monitor.
    task automatic settle(input string tag, input int edges);
        for (int c = 0; c < NC; c++) begin
            exp_t e;
            e.cpu = c;
            e.tag = tag;
            model(c, e.id, e.req);
            sb_q.push_back(e);
        end
        repeat (edges) @(posedge clk);
        @(negedge clk);
        -> chk_ev;
        #1;
    endtask

    always begin
        @(chk_ev);
        while (sb_q.size() > 0) begin
            exp_t e;
            int got_id;
            e = sb_q.pop_front();
            got_id = int'(hp_id[e.cpu*10 +: 10]);
            total++;
            if (got_id != e.id) begin
                bad++;
                $display("FAIL %s cpu%0d id: actual=%0d expected=%0d", e.tag, e.cpu, got_id, e.id);
            end
            total++;
            if (irq_req[e.cpu] != e.req) begin
                bad++;
                $display("FAIL %s cpu%0d req: actual=%0b expected=%0b", e.tag, e.cpu, irq_req[e.cpu], e.req);
            end
        end
    end

    task automatic set_bank(int c, int k, int p);
        prio_bank[(c*NB+k)*8 +: 8] = 8'(p);
    endtask

    task automatic set_shared(int k, int p);
        prio_shared[(k-NB)*8 +: 8] = 8'(p);
    endtask

    task automatic write_mask(int c, int v);
        @(negedge clk);
        mask_wr[c] = 1'b1;
        mask_wdata = 8'(v);
        @(negedge clk);
        mask_wr = '0;
        m_mask[c] = v;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < NC; c++) m_mask[c] = 8'hF0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle("R9 reset state", 0);

        // R4: distributor off, then one CPU interface off
        cpu_en = 2'b11;
        set_shared(40, 8'h20);
        irq_en[40] = 1'b1;
        irq_pend[0*N+40] = 1'b1;
        irq_pend[1*N+40] = 1'b1;
        settle("R4 dist off", 2);
        dist_en = 1'b1;
        cpu_en = 2'b10;
        settle("R4 cpu0 off", 2);
        cpu_en = 2'b11;

        // R1: lower value wins
        set_shared(50, 8'h10);
        irq_en[50] = 1'b1;
        irq_pend[0*N+50] = 1'b1;
        settle("R1 lower value", 2);

        // R2: tie goes to lower ID
        set_shared(35, 8'h10);
        irq_en[35] = 1'b1;
        irq_pend[0*N+35] = 1'b1;
        settle("R2 tie lower id", 2);

        // R3: pending-but-disabled ignored; pending only for other CPU
        set_shared(33, 8'h01);
        irq_pend[0*N+33] = 1'b1;
        set_shared(34, 8'h01);
        irq_en[34] = 1'b1;
        irq_pend[1*N+34] = 1'b1;
        settle("R3 candidacy", 2);

        // R10: one-edge latency
        @(negedge clk);
        irq_pend[1*N+34] = 1'b0;
        settle("R10 latency", 1);

        irq_en = '0;
        irq_pend = '0;
        settle("R3 nothing", 2);

        // R5 and R9: default mask 0xF0 boundary
        set_shared(60, 8'hF0);
        irq_en[60] = 1'b1;
        irq_pend[0*N+60] = 1'b1;
        irq_pend[1*N+60] = 1'b1;
        settle("R5 equal to mask", 2);
        set_shared(60, 8'hF1);
        settle("R9 mask F0 blocks F1", 2);

        // R11: load mask on cpu0 only
        write_mask(0, 8'hFF);
        settle("R11 cpu0 mask", 2);

        // R6: strict comparison with running priority
        set_shared(60, 8'h80);
        run_prio[0 +: 9] = 9'h080;
        settle("R6 equal running", 2);
        run_prio[0 +: 9] = 9'h081;
        settle("R6 below running", 2);

        // R7: idle running priority vs 0xFF
        set_shared(60, 8'hFF);
        run_prio[0 +: 9] = 9'h100;
        settle("R7 idle vs FF", 2);
        run_prio[0 +: 9] = 9'h0FF;
        settle("R7 FF vs FF", 2);
        run_prio[0 +: 9] = 9'h100;

        // R8: banked low ID, shared high ID
        irq_en = '0;
        irq_pend = '0;
        set_bank(0, 5, 8'h10);
        set_bank(1, 5, 8'h80);
        set_shared(40, 8'h40);
        irq_en[5] = 1'b1;
        irq_en[40] = 1'b1;
        irq_pend[0*N+5] = 1'b1;
        irq_pend[1*N+5] = 1'b1;
        irq_pend[0*N+40] = 1'b1;
        irq_pend[1*N+40] = 1'b1;
        settle("R8 banked vs shared", 2);

        write_mask(1, 8'h30);
        settle("R11 cpu1 mask", 2);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule